// File: doc/BRIEF.md
# Serial Trim Programming Port

This block is the configuration port that sets the reference trims and protection options of a supply supervisor. While the program-enable input is high, two pins are reused: one carries a serial clock and the other carries serial data. Eight-bit frames are shifted in on the falling edge of the serial clock. Each frame holds a 4-bit value and a 4-bit target address. A frame either loads one volatile nibble or, as one reserved code, commits every nibble to a write-once fuse store.

The outputs are signed offsets that the analog side applies to its references:
- the main reference offset and the AC-sense threshold offset, both in millivolts;
- the offsets for the two 1.25 V loop references;
- the hysteresis current offset, in tenths of a microampere;
- four option bits.

The serial pins are synchronised into the system clock domain. The fuse operation is modelled as a fixed busy window. When the window ends, the fuse copy becomes the source of the outputs.

Top module: `trim_prog_port`

## Requirements
- R1: Serial clock edges are acted on only while prog_en_i is high. When prog_en_i falls, a partly received frame is discarded, and the next frame starts again at bit 0.
- R2: A bit is taken on each falling edge of ser_clk_i, most significant bit first. In the finished frame, bits 7..4 are the value V and bits 3..0 are the address.
- R3: Address 1 sets ref_main_o to V as 4-bit two's complement times 16 mV. The range is -128..+112.
- R4: Address 2 sets ref_post_o and address 3 sets ref_aux_o. Each is V as two's complement times 8 mV, with range -64..+56.
- R5: Address 4 sets ac_thr_o to V as two's complement times 16 mV.
- R6: Address 5 has two fields. V bits 2..0 are a 3-bit two's complement hysteresis code, and hyst_o is that code times 25 (units of 0.1 uA, range -100..+75). V bit 3 drives bounce_o (0 = latch, 1 = bounce).
- R7: Address 6 drives three option bits from V. Bit 3 drives mon12_dis_o, bit 2 drives mon5_dis_o and bit 1 drives aux_3v3_o. Bit 0 has no effect.
- R8: After rst_ni, all outputs are zero.
- R9: Frames with address 0, 7..14, or 15 with a non-zero value change no output.
- R10: While uvlo_i is high, all volatile nibbles are cleared.
- R11: Frame 0x0F starts a burn. BURN_CYCLES clocks later, the volatile contents are copied to the fuse store, and from then on the outputs come from the fuse copy.
- R12: Once a burn has started, further frames are ignored and the fuse contents never change. After the burn, uvlo_i does not alter the outputs.
- R13: An output reflects a frame four clk_i rising edges after the last falling edge of ser_clk_i in that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| prog_en_i | input | 1 | Programming mode enable |
| ser_clk_i | input | 1 | Serial clock (reused power-on pin) |
| ser_data_i | input | 1 | Serial data (reused power-good pin) |
| uvlo_i | input | 1 | Supply below lockout; clears volatile nibbles |
| ref_main_o | output | 8 | Main reference offset, signed mV |
| ref_post_o | output | 8 | 3.3 V loop reference offset, signed mV |
| ref_aux_o | output | 8 | Auxiliary reference offset, signed mV |
| ac_thr_o | output | 8 | AC-sense threshold offset, signed mV |
| hyst_o | output | 8 | Hysteresis current offset, signed 0.1 uA |
| bounce_o | output | 1 | 1 = bounce mode, 0 = latch mode |
| mon12_dis_o | output | 1 | 12 V monitor disabled |
| mon5_dis_o | output | 1 | 5 V monitor disabled |
| aux_3v3_o | output | 1 | Auxiliary monitor set to 3.3 V |

## Verification
A frame's effect on the outputs is due four rising clk_i edges after its final serial falling edge. Two of those edges are the synchroniser, one is the frame capture and one is the register write. The bench holds each serial phase for four system clocks and samples on a falling clk_i edge eight cycles after the final serial edge, so every result has settled by the time it is read. A burn result is due BURN_CYCLES after the write edge, and the bench waits beyond that window before it compares the fuse-sourced outputs.

// File: rtl/trim_prog_pkg.sv
package trim_prog_pkg;
  localparam int NIB_W    = 4;
  localparam int FRAME_W  = 2 * NIB_W;
  localparam int NUM_REGS = 6;
  localparam int NUM_REFS = 4;
  localparam int OUT_W    = 8;
  localparam logic [NIB_W-1:0] ADDR_BURN = '1;

  typedef logic [NIB_W-1:0] nib_t;

  typedef struct packed {
    nib_t val;
    nib_t addr;
  } frame_t;

  // log2 of the step per code: 16 mV for 2.5 V refs, 8 mV for 1.25 V refs
  function automatic int ref_shift(int idx);
    return (idx == 1 || idx == 2) ? 3 : 4;
  endfunction
endpackage

// File: rtl/trim_sync.sv
module trim_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ser_clk_i,
  input  logic ser_data_i,
  output logic fall_o,
  output logic bit_o
);
  logic [STAGES:0]   clk_q;
  logic [STAGES-1:0] dat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_q <= '0;
      dat_q <= '0;
    end else begin
      clk_q <= {clk_q[STAGES-1:0], ser_clk_i};
      dat_q <= {dat_q[STAGES-2:0], ser_data_i};
    end
  end

  assign fall_o = clk_q[STAGES] & ~clk_q[STAGES-1];
  assign bit_o  = dat_q[STAGES-1];
endmodule

// File: rtl/trim_shift.sv
module trim_shift
  import trim_prog_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   prog_en_i,
  input  logic   fall_i,
  input  logic   bit_i,
  output logic   frame_vld_o,
  output frame_t frame_o
);
  localparam int CNT_W = $clog2(FRAME_W);

  logic [CNT_W-1:0]   cnt_q;
  logic [FRAME_W-1:0] sr_q;
  logic [FRAME_W-1:0] sr_next;
  logic               vld_q;
  frame_t             frame_q;

  assign sr_next = {sr_q[FRAME_W-2:0], bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      sr_q    <= '0;
      vld_q   <= 1'b0;
      frame_q <= '0;
    end else begin
      vld_q <= 1'b0;
      if (!prog_en_i) begin
        cnt_q <= '0;
      end else if (fall_i) begin
        sr_q <= sr_next;
        if (cnt_q == CNT_W'(FRAME_W - 1)) begin
          cnt_q   <= '0;
          vld_q   <= 1'b1;
          frame_q <= frame_t'(sr_next);
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign frame_vld_o = vld_q;
  assign frame_o     = frame_q;

  assert_frame_in_prog_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |-> $past(prog_en_i));
  assert_frame_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |=> !vld_q);
endmodule

// File: rtl/trim_store.sv
module trim_store
  import trim_prog_pkg::*;
#(
  parameter int BURN_CYCLES = 375000
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      uvlo_i,
  input  logic                      frame_vld_i,
  input  frame_t                    frame_i,
  output logic [NUM_REGS*NIB_W-1:0] word_o
);
  localparam int BC_W = $clog2(BURN_CYCLES + 1);

  logic [NUM_REGS-1:0][NIB_W-1:0] vol_q, fuse_q;
  logic                           busy_q, burned_q;
  logic [BC_W-1:0]                bcnt_q;
  logic                           locked, is_burn;

  assign locked  = busy_q | burned_q;
  assign is_burn = frame_vld_i && frame_i.addr == ADDR_BURN && frame_i.val == '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vol_q <= '0;
    end else if (uvlo_i) begin
      vol_q <= '0;
    end else if (frame_vld_i && !locked) begin
      for (int i = 0; i < NUM_REGS; i++)
        if (frame_i.addr == NIB_W'(i + 1)) vol_q[i] <= frame_i.val;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      burned_q <= 1'b0;
      bcnt_q   <= '0;
      fuse_q   <= '0;
    end else if (is_burn && !locked) begin
      busy_q <= 1'b1;
      bcnt_q <= '0;
    end else if (busy_q) begin
      if (bcnt_q == BC_W'(BURN_CYCLES - 1)) begin
        busy_q   <= 1'b0;
        burned_q <= 1'b1;
        fuse_q   <= vol_q;
      end else begin
        bcnt_q <= bcnt_q + 1'b1;
      end
    end
  end

  assign word_o = burned_q ? fuse_q : vol_q;

  assert_uvlo_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uvlo_i |=> vol_q == '0);
  assert_fuse_once_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burned_q |=> burned_q && $stable(fuse_q));
  assert_burn_phase_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({busy_q, burned_q}));
  assert_lock_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked && !uvlo_i) |=> $stable(vol_q));
endmodule

// File: rtl/trim_decode.sv
module trim_decode
  import trim_prog_pkg::*;
(
  input  logic [NUM_REGS*NIB_W-1:0] word_i,
  output logic [NUM_REFS-1:0][OUT_W-1:0] ref_o,
  output logic [OUT_W-1:0]          hyst_o,
  output logic [NIB_W-1:0]          mode_o
);
  logic [NUM_REGS-1:0][NIB_W-1:0] nib;
  logic [OUT_W-1:0]               hx;

  assign nib = word_i;

  for (genvar g = 0; g < NUM_REFS; g++) begin : g_ref
    logic [OUT_W-1:0] sx;
    assign sx       = {{(OUT_W-NIB_W){nib[g][NIB_W-1]}}, nib[g]};
    assign ref_o[g] = sx << ref_shift(g);
  end

  // 3-bit code times 25
  assign hx     = {{(OUT_W-3){nib[4][2]}}, nib[4][2:0]};
  assign hyst_o = (hx << 4) + (hx << 3) + hx;
  // {bounce, 12V off, 5V off, aux 3.3V}
  assign mode_o = {nib[4][3], nib[5][3:1]};
endmodule

// File: rtl/trim_prog_port.sv
module trim_prog_port
  import trim_prog_pkg::*;
#(
  parameter int BURN_CYCLES = 375000,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    prog_en_i,
  input  logic                    ser_clk_i,
  input  logic                    ser_data_i,
  input  logic                    uvlo_i,
  output logic signed [OUT_W-1:0] ref_main_o,
  output logic signed [OUT_W-1:0] ref_post_o,
  output logic signed [OUT_W-1:0] ref_aux_o,
  output logic signed [OUT_W-1:0] ac_thr_o,
  output logic signed [OUT_W-1:0] hyst_o,
  output logic                    bounce_o,
  output logic                    mon12_dis_o,
  output logic                    mon5_dis_o,
  output logic                    aux_3v3_o
);
  logic                           fall, sbit, frame_vld;
  frame_t                         frame;
  logic [NUM_REGS*NIB_W-1:0]      word;
  logic [NUM_REFS-1:0][OUT_W-1:0] refs;
  logic [OUT_W-1:0]               hyst;
  logic [NIB_W-1:0]               mode;

  trim_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .ser_clk_i, .ser_data_i,
    .fall_o(fall), .bit_o(sbit)
  );

  trim_shift u_shift (
    .clk_i, .rst_ni, .prog_en_i,
    .fall_i(fall), .bit_i(sbit),
    .frame_vld_o(frame_vld), .frame_o(frame)
  );

  trim_store #(.BURN_CYCLES(BURN_CYCLES)) u_store (
    .clk_i, .rst_ni, .uvlo_i,
    .frame_vld_i(frame_vld), .frame_i(frame), .word_o(word)
  );

  trim_decode u_dec (
    .word_i(word), .ref_o(refs), .hyst_o(hyst), .mode_o(mode)
  );

  assign ref_main_o  = refs[0];
  assign ref_post_o  = refs[1];
  assign ref_aux_o   = refs[2];
  assign ac_thr_o    = refs[3];
  assign hyst_o      = hyst;
  assign bounce_o    = mode[3];
  assign mon12_dis_o = mode[2];
  assign mon5_dis_o  = mode[1];
  assign aux_3v3_o   = mode[0];

  assert_main_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_main_o[3:0] == '0 && ref_main_o <= 8'sd112);
  assert_loop_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_post_o[2:0] == '0 && ref_aux_o[2:0] == '0 &&
    ref_post_o >= -8'sd64 && ref_post_o <= 8'sd56 &&
    ref_aux_o >= -8'sd64 && ref_aux_o <= 8'sd56);
  assert_hyst_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hyst_o >= -8'sd100 && hyst_o <= 8'sd75);
  assert_idle_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!prog_en_i && !uvlo_i && $past(!prog_en_i) && $past(!prog_en_i, 2) &&
     $past(!uvlo_i)) |=> $stable(ref_main_o));
endmodule

// File: tb/tb_trim_prog_port.sv
module tb_trim_prog_port;
  localparam int BURN = 40;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic prog_en = 1'b0, sclk = 1'b0, sdat = 1'b0, uvlo = 1'b0;
  logic signed [7:0] ref_main, ref_post, ref_aux, ac_thr, hyst;
  logic bounce, d12, d5, a33;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  trim_prog_port #(.BURN_CYCLES(BURN)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .prog_en_i(prog_en), .ser_clk_i(sclk),
    .ser_data_i(sdat), .uvlo_i(uvlo), .ref_main_o(ref_main),
    .ref_post_o(ref_post), .ref_aux_o(ref_aux), .ac_thr_o(ac_thr),
    .hyst_o(hyst), .bounce_o(bounce), .mon12_dis_o(d12),
    .mon5_dis_o(d5), .aux_3v3_o(a33)
  );

  // {frame, output select, expected}; select 5 = {bounce, 12V off, 5V off, aux 3.3V}
  localparam logic [18:0] VEC [13] = '{
    {8'h71, 3'd0, 8'h70},   // R3 +112
    {8'h81, 3'd0, 8'h80},   // R3 -128
    {8'hF2, 3'd1, 8'hF8},   // R4 -8
    {8'h72, 3'd1, 8'h38},   // R4 +56
    {8'h83, 3'd2, 8'hC0},   // R4 -64
    {8'h14, 3'd3, 8'h10},   // R5 +16
    {8'hC5, 3'd4, 8'h9C},   // R6 -100
    {8'h35, 3'd4, 8'h4B},   // R6 +75
    {8'hB6, 3'd5, 8'h05},   // R7 D0 ignored
    {8'h85, 3'd5, 8'h0D},   // R6 bounce
    {8'h47, 3'd0, 8'h80},   // R9 addr 7
    {8'h5F, 3'd0, 8'h80},   // R9 addr 15 nonzero
    {8'h00, 3'd1, 8'h38}    // R9 addr 0
  };
  localparam string VTAG [13] = '{"R3","R3","R4","R4","R4","R5","R6","R6",
                                   "R7","R6","R9","R9","R9"};

  function automatic logic [7:0] get_out(logic [2:0] sel);
    case (sel)
      3'd0: return ref_main;
      3'd1: return ref_post;
      3'd2: return ref_aux;
      3'd3: return ac_thr;
      3'd4: return hyst;
      default: return {4'b0, bounce, d12, d5, a33};
    endcase
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_bit(logic b);
    @(negedge clk);
    sdat = b;
    sclk = 1'b1;
    repeat (4) @(negedge clk);
    sclk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_frame(logic [7:0] f);
    for (int i = 7; i >= 0; i--) send_bit(f[i]);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    // R8 reset state
    for (int s = 0; s < 6; s++) check("R8", get_out(3'(s)), 8'h00);

    prog_en = 1'b1;
    repeat (2) @(negedge clk);
    // R2 R13 table walk
    for (int v = 0; v < 13; v++) begin
      send_frame(VEC[v][18:11]);
      check(VTAG[v], get_out(VEC[v][10:8]), VEC[v][7:0]);
    end

    // R1 partial frame dropped on prog_en fall
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    prog_en = 1'b0;
    repeat (4) @(negedge clk);
    prog_en = 1'b1;
    repeat (2) @(negedge clk);
    send_frame(8'h21);
    check("R1", ref_main, 8'h20);
    check("R1", ref_post, 8'h38);

    // R1 serial activity with prog_en low ignored
    prog_en = 1'b0;
    send_frame(8'h41);
    check("R1", ref_main, 8'h20);
    prog_en = 1'b1;
    repeat (2) @(negedge clk);

    // R10 undervoltage clears volatile
    uvlo = 1'b1;
    repeat (2) @(negedge clk);
    uvlo = 1'b0;
    @(negedge clk);
    check("R10", ref_main, 8'h00);
    check("R10", {4'b0, bounce, d12, d5, a33}, 8'h00);

    // R11 burn commits volatile contents
    send_frame(8'h31);
    send_frame(8'hA3);
    check("R11", ref_main, 8'h30);
    send_frame(8'h0F);
    repeat (BURN + 10) @(negedge clk);
    check("R11", ref_main, 8'h30);
    check("R11", ref_aux, 8'hD0);

    // R12 writes and undervoltage after burn have no effect
    send_frame(8'h61);
    check("R12", ref_main, 8'h30);
    uvlo = 1'b1;
    repeat (2) @(negedge clk);
    uvlo = 1'b0;
    @(negedge clk);
    check("R12", ref_main, 8'h30);
    check("R12", ref_aux, 8'hD0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule